// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

This block is a single down-counting timer channel that produces a pulse-width-modulated waveform. Two reload registers set the phase lengths in input clock cycles. One sets the low phase and the other sets the high phase. Each phase lasts its reload value plus one cycle. Neither phase can be shorter than one cycle, so the output never holds a 0 % or a 100 % duty cycle while it toggles.

Software reaches the channel through a small synchronous register port. That port holds the two reload values, a control word, a live view of the counter, an interrupt status flag, and an acknowledge location that clears the flag when it is read. The control word selects between a free-running count, which wraps through all-ones, and a user-defined reload. A separate control bit turns on output toggling. The channel can be built wider than the default 32-bit counter, and the data bus can be built wider than the counter.

Top module: `pwmt_channel`

## Requirements
- R1: After reset every register reads zero, `pwm_out` is low and `irq` is low.
- R2: The register map uses byte offsets. 0x00 is the low-phase reload (RW), 0x04 is the live count (RO), 0x08 is the control word (RW, bits 3:0), 0x0C is the acknowledge location (RO, returns the status and clears it), 0x10 is the status (RO, bit 0) and 0x14 is the high-phase reload (RW). Any other offset reads zero. In the control word, bit 0 is enable, bit 1 selects user reload (0 = free-running), bit 2 masks the interrupt and bit 3 turns on toggling.
- R3: A control write that takes enable from 0 to 1 loads the low-phase reload into the counter, and the output starts in the low phase.
- R4: With enable, user reload and toggling all set, the output stays low for (low reload + 1) cycles and then high for (high reload + 1) cycles, and this repeats.
- R5: In user reload mode without toggling, the counter reloads the low-phase value each time it reaches zero, and the output stays low.
- R6: In free-running mode, a counter at zero wraps to all-ones, and the output stays low whatever the toggle bit says.
- R7: A write to either reload register while the channel is enabled restarts the counter from the reload value of the current phase, using the new value. The same write made while the channel is disabled leaves the counter unchanged.
- R8: Clearing enable forces the output low and freezes the counter.
- R9: When enabled, the counter expires on any cycle in which it is zero. Each expiry sets the status flag while the mask bit is clear. Expiries with the mask set leave the flag alone.
- R10: Reading the acknowledge location clears the flag. If an expiry falls in the same cycle, the set takes priority.
- R11: A read of the live-count location returns the counter value of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has a side effect on the acknowledge location) |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt status flag |

## Verification
Read data is combinational. The bench therefore samples `rdata` 1 ns after it drives a read at a falling edge, before any clock edge. Writes, reloads, expiries and flag changes become visible at the first falling edge after the rising edge that consumes the strobe. The bench drives and samples only on falling edges, so it knows exactly how many counter steps each read uses. Phase widths are measured by counting falling-edge samples, starting at the falling edge right after the enabling write. That makes the first low run equal to the reload plus one.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;

   // Control word, bit 0 at the bottom (positions decoded by software)
   typedef struct packed {
      logic toggle;   // bit 3
      logic irq_mask; // bit 2
      logic user;     // bit 1
      logic en;       // bit 0
   } ctrl_t;

   typedef enum logic [2:0] {
      SEL_LOAD_LO = 3'd0,
      SEL_COUNT   = 3'd1,
      SEL_CTRL    = 3'd2,
      SEL_ACK     = 3'd3,
      SEL_STATUS  = 3'd4,
      SEL_LOAD_HI = 3'd5,
      SEL_NONE    = 3'd7
   } reg_sel_e;

   localparam int unsigned CTRL_W = 4;

   function automatic reg_sel_e decode_offset(input logic [31:0] off);
      reg_sel_e s;
      if (off[1:0] != 2'b00) begin
         s = SEL_NONE;
      end else begin
         case (off)
            32'h00:  s = SEL_LOAD_LO;
            32'h04:  s = SEL_COUNT;
            32'h08:  s = SEL_CTRL;
            32'h0C:  s = SEL_ACK;
            32'h10:  s = SEL_STATUS;
            32'h14:  s = SEL_LOAD_HI;
            default: s = SEL_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/pwmt_regs.sv
`timescale 1ns/1ps
module pwmt_regs
   import pwmt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              status,
   output logic [CNT_W-1:0]  load_lo,
   output logic [CNT_W-1:0]  load_hi,
   output ctrl_t             ctrl,
   output logic              start,
   output logic              wr_lo,
   output logic              wr_hi,
   output logic [CNT_W-1:0]  wval,
   output logic              ack_rd,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned PAD_W = DATA_W - CNT_W;

   logic [31:0]       addr_ext;
   reg_sel_e          sel;
   logic [DATA_W-1:0] lo_ext, hi_ext, cnt_ext, ctrl_ext, stat_ext;
   logic              unused_wbits;

   assign addr_ext = 32'(addr);
   assign sel      = decode_offset(addr_ext);
   assign wval     = wdata[CNT_W-1:0];

   assign wr_lo  = wr_en && (sel == SEL_LOAD_LO);
   assign wr_hi  = wr_en && (sel == SEL_LOAD_HI);
   assign start  = wr_en && (sel == SEL_CTRL) && wdata[0] && !ctrl.en;
   assign ack_rd = rd_en && (sel == SEL_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_lo <= '0;
         load_hi <= '0;
         ctrl    <= '0;
      end else begin
         if (wr_lo) load_lo <= wval;
         if (wr_hi) load_hi <= wval;
         if (wr_en && (sel == SEL_CTRL)) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

   // Zero extension to the bus width, chosen by the width difference
   generate
      if (PAD_W > 0) begin : g_pad
         assign lo_ext  = {{PAD_W{1'b0}}, load_lo};
         assign hi_ext  = {{PAD_W{1'b0}}, load_hi};
         assign cnt_ext = {{PAD_W{1'b0}}, cnt_val};
         assign unused_wbits = ^wdata[DATA_W-1:CNT_W];
      end else begin : g_nopad
         assign lo_ext  = load_lo;
         assign hi_ext  = load_hi;
         assign cnt_ext = cnt_val;
         assign unused_wbits = 1'b0;
      end
   endgenerate

   assign ctrl_ext = DATA_W'(ctrl);
   assign stat_ext = DATA_W'(status);

   always_comb begin
      case (sel)
         SEL_LOAD_LO: rdata = lo_ext;
         SEL_LOAD_HI: rdata = hi_ext;
         SEL_COUNT:   rdata = cnt_ext;
         SEL_CTRL:    rdata = ctrl_ext;
         SEL_ACK:     rdata = stat_ext;
         SEL_STATUS:  rdata = stat_ext;
         default:     rdata = '0;
      endcase
   end

   // A start pulse leaves the channel enabled on the next cycle (R3)
   assert_start_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ctrl.en);

endmodule

// File: rtl/pwmt_counter.sv
`timescale 1ns/1ps
module pwmt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             user,
   input  logic             toggle,
   input  logic             start,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [CNT_W-1:0] wval,
   input  logic [CNT_W-1:0] load_lo,
   input  logic [CNT_W-1:0] load_hi,
   output logic [CNT_W-1:0] cnt_q,
   output logic             phase_q,
   output logic             expire
);

   localparam logic [CNT_W-1:0] WRAP_VAL = {CNT_W{1'b1}};

   logic             at_zero, wr_any, toggling;
   logic [CNT_W-1:0] lo_eff, hi_eff, phase_reload;

   assign at_zero  = (cnt_q == '0);
   assign wr_any   = wr_lo || wr_hi;
   assign toggling = user && toggle;
   assign expire   = run && at_zero;

   // Reload values seen by a write in flight (new value takes effect)
   assign lo_eff = wr_lo ? wval : load_lo;
   assign hi_eff = wr_hi ? wval : load_hi;
   assign phase_reload = (toggling && phase_q) ? hi_eff : lo_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (start) begin
         cnt_q   <= load_lo;
         phase_q <= 1'b0;
      end else if (run) begin
         if (wr_any) begin
            cnt_q <= phase_reload;
         end else if (at_zero) begin
            if (!user) begin
               cnt_q <= WRAP_VAL;
            end else if (toggle) begin
               phase_q <= !phase_q;
               cnt_q   <= phase_q ? load_lo : load_hi;
            end else begin
               cnt_q <= load_lo;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(cnt_q));

   assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == $past(load_lo) && !phase_q));

   assert_free_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !user && at_zero && !wr_any) |=> (cnt_q == WRAP_VAL));

   assert_user_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && user && !toggle && at_zero && !wr_any) |=> (cnt_q == $past(load_lo)));

   assert_phase_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && toggling && at_zero && !wr_any) |=> (phase_q != $past(phase_q)));

   assert_running_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wr_lo && !(toggling && phase_q)) |=> (cnt_q == $past(wval)));

endmodule

// File: rtl/pwmt_irq.sv
`timescale 1ns/1ps
module pwmt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic irq_mask,
   input  logic ack_rd,
   output logic status
);

   logic set_evt;
   assign set_evt = expire && !irq_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       status <= 1'b0;
      else if (set_evt) status <= 1'b1;
      else if (ack_rd)  status <= 1'b0;
   end

   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !irq_mask) |=> status);

   assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !(expire && !irq_mask)) |=> !status);

   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!status && (!expire || irq_mask)) |=> !status);

endmodule

// File: rtl/pwmt_channel.sv
`timescale 1ns/1ps
module pwmt_channel
   import pwmt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pwm_out,
   output logic              irq
);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("pwmt_channel: CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data_w
         $error("pwmt_channel: DATA_W narrower than the control word");
      end
      if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr_w
         $error("pwmt_channel: ADDR_W must lie in 5..32");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] load_lo, load_hi, wval, cnt_q;
   logic             start, wr_lo, wr_hi, ack_rd;
   logic             phase_q, expire, status;

   pwmt_regs #(
      .CNT_W (CNT_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .cnt_val(cnt_q),
      .status (status),
      .load_lo(load_lo),
      .load_hi(load_hi),
      .ctrl   (ctrl),
      .start  (start),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wval   (wval),
      .ack_rd (ack_rd),
      .rdata  (rdata)
   );

   pwmt_counter #(
      .CNT_W(CNT_W)
   ) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl.en),
      .user   (ctrl.user),
      .toggle (ctrl.toggle),
      .start  (start),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wval   (wval),
      .load_lo(load_lo),
      .load_hi(load_hi),
      .cnt_q  (cnt_q),
      .phase_q(phase_q),
      .expire (expire)
   );

   pwmt_irq irq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (expire),
      .irq_mask(ctrl.irq_mask),
      .ack_rd  (ack_rd),
      .status  (status)
   );

   assign pwm_out = ctrl.en && ctrl.user && ctrl.toggle && phase_q;
   assign irq     = status;

   assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !pwm_out);

   assert_free_no_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.en && !ctrl.user) |-> !pwm_out);

endmodule

// File: tb/pwmt_channel_tb_top.sv
`timescale 1ns/1ps
module pwmt_channel_tb_top;

   localparam int CNT_W  = 32;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 5;

   localparam logic [ADDR_W-1:0] A_LO   = 5'h00;
   localparam logic [ADDR_W-1:0] A_CNT  = 5'h04;
   localparam logic [ADDR_W-1:0] A_CTRL = 5'h08;
   localparam logic [ADDR_W-1:0] A_ACK  = 5'h0C;
   localparam logic [ADDR_W-1:0] A_STAT = 5'h10;
   localparam logic [ADDR_W-1:0] A_HI   = 5'h14;

   localparam logic [31:0] C_PWM  = 32'hB; // en | user | toggle
   localparam logic [31:0] C_USER = 32'h3; // en | user
   localparam logic [31:0] C_FREE = 32'h9; // en | toggle, free-running
   localparam logic [31:0] C_MASK = 32'h7; // en | user | mask

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              pwm_out;
   logic              irq;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #2 clk = !clk;

   pwmt_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
   );

   function automatic int exp_low(input int lo_reload);
      return lo_reload + 1;
   endfunction

   function automatic int exp_high(input int hi_reload);
      return hi_reload + 1;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge
   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(output int lo, output int hi);
      lo = 0;
      while (pwm_out == 1'b0 && lo < 500) begin lo++; @(negedge clk); end
      hi = 0;
      while (pwm_out == 1'b1 && hi < 500) begin hi++; @(negedge clk); end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all requirements actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v2;
      int lo, hi, lo2, hi2;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pwm_out", 64'(pwm_out), 64'd0);
      chk("R1 irq", 64'(irq), 64'd0);
      rd(A_CTRL, v); chk("R1 ctrl", 64'(v), 64'd0);
      rd(A_LO, v);   chk("R1 load_lo", 64'(v), 64'd0);
      rd(A_CNT, v);  chk("R1 count", 64'(v), 64'd0);
      rd(A_STAT, v); chk("R1 status", 64'(v), 64'd0);

      // R2 register map readback
      wr(A_LO, 32'd3);
      wr(A_HI, 32'd5);
      rd(A_LO, v);   chk("R2 load_lo readback", 64'(v), 64'd3);
      rd(A_HI, v);   chk("R2 load_hi readback", 64'(v), 64'd5);
      rd(5'h18, v);  chk("R2 unmapped reads zero", 64'(v), 64'd0);

      // R3 start state, R11 live count, R4 phase widths
      wr(A_CTRL, C_PWM);
      chk("R3 output low after enable", 64'(pwm_out), 64'd0);
      rd(A_CNT, v);  chk("R3 R11 count loaded", 64'(v), 64'd3);
      rd(A_CTRL, v); chk("R2 ctrl readback", 64'(v), 64'hB);
      measure(lo, hi);
      chk("R4 first low remainder", 64'(lo), 64'(exp_low(3) - 2));
      chk("R4 first high", 64'(hi), 64'(exp_high(5)));
      measure(lo, hi);
      chk("R4 low width", 64'(lo), 64'(exp_low(3)));
      chk("R4 high width", 64'(hi), 64'(exp_high(5)));

      // R4 random reload pairs
      for (int i = 0; i < 8; i++) begin
         int l, h;
         l = int'($urandom % 13);
         h = int'($urandom % 13);
         wr(A_CTRL, 32'h0);
         wr(A_LO, 32'(l));
         wr(A_HI, 32'(h));
         wr(A_CTRL, C_PWM);
         measure(lo, hi);
         measure(lo2, hi2);
         chk("R4 random first low", 64'(lo), 64'(exp_low(l)));
         chk("R4 random high", 64'(hi), 64'(exp_high(h)));
         chk("R4 random second low", 64'(lo2), 64'(exp_low(l)));
         chk("R4 random second high", 64'(hi2), 64'(exp_high(h)));
      end

      // R5 user reload without toggling, R9 and R10 flag handling
      wr(A_CTRL, 32'h0);
      rd(A_ACK, v);
      wr(A_LO, 32'd2);
      wr(A_CTRL, C_USER);
      rd(A_CNT, v); chk("R5 count 2", 64'(v), 64'd2);
      rd(A_CNT, v); chk("R5 count 1", 64'(v), 64'd1);
      rd(A_CNT, v); chk("R5 count 0", 64'(v), 64'd0);
      chk("R9 flag set on expiry", 64'(irq), 64'd1);
      rd(A_CNT, v); chk("R5 reload low value", 64'(v), 64'd2);
      chk("R5 output low", 64'(pwm_out), 64'd0);
      rd(A_ACK, v); chk("R10 ack returns flag", 64'(v), 64'd1);
      chk("R10 flag cleared", 64'(irq), 64'd0);
      rd(A_ACK, v); // counter at zero here: expiry in the same cycle
      chk("R10 set wins over ack", 64'(irq), 64'd1);

      // R9 masked expiries
      wr(A_CTRL, 32'h0);
      rd(A_ACK, v);
      wr(A_LO, 32'd0);
      wr(A_CTRL, C_MASK);
      idle(6);
      chk("R9 masked expiries keep flag low", 64'(irq), 64'd0);

      // R6 free-running wrap, toggle ignored
      wr(A_CTRL, 32'h0);
      rd(A_ACK, v);
      wr(A_LO, 32'd1);
      wr(A_CTRL, C_FREE);
      rd(A_CNT, v); chk("R6 count 1", 64'(v), 64'd1);
      rd(A_CNT, v); chk("R6 count 0", 64'(v), 64'd0);
      rd(A_CNT, v); chk("R6 wrap to all ones", 64'(v), 64'hFFFF_FFFF);
      chk("R6 output low in free mode", 64'(pwm_out), 64'd0);
      chk("R9 flag set in free mode", 64'(irq), 64'd1);

      // R7 reload write while running and while disabled
      wr(A_CTRL, 32'h0);
      wr(A_LO, 32'd30);
      wr(A_HI, 32'd30);
      wr(A_CTRL, C_PWM);
      idle(4);
      wr(A_LO, 32'd7);
      rd(A_CNT, v); chk("R7 running write reloads", 64'(v), 64'd7);
      wr(A_CTRL, 32'h0);
      rd(A_CNT, v);
      wr(A_LO, 32'd12);
      rd(A_CNT, v2); chk("R7 disabled write no reload", 64'(v2), 64'(v));

      // R8 disable during the high phase
      wr(A_LO, 32'd0);
      wr(A_HI, 32'd40);
      wr(A_CTRL, C_PWM);
      idle(3);
      chk("R8 high before disable", 64'(pwm_out), 64'd1);
      wr(A_CTRL, 32'h0);
      chk("R8 output forced low", 64'(pwm_out), 64'd0);
      rd(A_CNT, v);
      idle(3);
      rd(A_CNT, v2); chk("R8 counter frozen", 64'(v2), 64'(v));

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule